// File: doc/BRIEF.md
# Banked Word Access Sequencer

This block connects a 16-bit processor core to a 1 MB byte-addressed memory. The memory is built from two 8-bit banks. The even bank holds every even byte address and carries its data on bus bits 7:0. The odd bank holds every odd byte address and carries its data on bus bits 15:8. The core issues one byte or word request at a time, with a 20-bit byte address. The sequencer turns that request into one or two bus cycles. In each cycle it selects the right banks and places each byte on the lane that belongs to its bank. When a read completes, it returns the result right-justified to the core.

Each bus cycle has two phases. In the address phase the latch strobe is high, the low 16 address bits are driven on the shared address/data lines and the top 4 bits are driven on their own pins. In the data phase the read or write strobe is active, and the phase lasts until the memory raises ready. Words are little-endian. A word at an even address moves in one cycle on both lanes. A word at an odd address is split into two cycles: the low byte goes at the odd address and the high byte at the next address, which wraps modulo 2^20. The two halves are merged before the core sees a single completion pulse.

The controller walks four named states:
- IDLE moves to ADDR when a request is accepted.
- ADDR always moves to DATA after one clock.
- DATA stays in DATA while ready is low. When ready is high, DATA moves back to ADDR for the second half of a split word, and otherwise moves to FINISH.
- FINISH pulses completion and returns to IDLE.

Top module: `banked_access_seq`

## Requirements
- R1: While reset is asserted, and on leaving it, the block is inactive: `ale`=0, `rd_n`=1, `wr_n`=1, `hi_en_n`=1, `ad_oe`=0, `busy`=0, `done`=0.
- R2: Each bus cycle consists of an address phase and a data phase.
  - The address phase lasts one clock, with `ale`=1, `ad_out` equal to address bits 15:0, `a_hi` equal to address bits 19:16 and `ad_oe`=1.
  - It is followed directly by a data phase with exactly one of `rd_n`/`wr_n` low. That strobe stays low until a clock edge at which `ready`=1.
- R3: Bank selection is set in the address phase and held through the data phase.
  - The even bank is selected when `ad_out[0]`=0.
  - The odd bank is selected when `hi_en_n`=0.
  - A byte access selects exactly one bank.
- R4: Lane steering: even-address bytes travel on bus bits 7:0 and odd-address bytes travel on bus bits 15:8, for both reads and writes.
- R5: A word at an even address takes one bus cycle with both banks selected. Bits 7:0 of the word sit at the address and bits 15:8 at the address plus one.
- R6: A word at an odd address A takes two bus cycles.
  - The first cycle uses address A, odd bank only, and moves word bits 7:0 on lane 15:8.
  - The second cycle uses address A+1, even bank only, and moves word bits 15:8 on lane 7:0.
  - A read returns the merged 16-bit word.
- R7: A byte read returns the byte in `rdata[7:0]` with `rdata[15:8]`=0. The lane of the other bank is ignored.
- R8: `done` is a single-cycle pulse. It comes in the clock after the data phase of the last bus cycle ends with `ready`=1, and `rdata` is valid while it is high.
  - With `ready` always high, completion comes 2 clocks after the accepting edge for one bus cycle, and 4 clocks after it for a split word.
  - Each low-`ready` clock adds one clock.
- R9: A request is accepted only in IDLE. `busy` is high from the accepting edge until the FINISH state ends. A request presented while `busy` is high is ignored and starts no bus cycle.
- R10: The second address of a split word wraps modulo 2^20, so an odd word at 0xFFFFF places its high byte at 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| busy | output | 1 | Sequencer is not idle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, right-justified |
| ale | output | 1 | Address phase strobe |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 16 | Shared address/data lines, sampled value |
| a_hi | output | 4 | Address bits 19:16 |
| hi_en_n | output | 1 | Active-low odd bank select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ready | input | 1 | Memory ready; ends the data phase |

## Verification
The main function is exercised with five patterns:
- even-address words;
- even-address bytes;
- odd-address bytes;
- odd-address words;
- an odd word at the top of the address space.

Each pattern is written through the sequencer and read back in a different width. This separates lane-steering errors, byte-order errors and wrong bank enables, which a same-width round trip would hide.

The bench memory drives a marker value on any lane whose bank is not selected. A read that takes the wrong lane therefore fails visibly.

Ready stall patterns distinguish a data phase that waits from one that ends early. A request held during a busy transfer shows whether the sequencer accepts work it should refuse.

// File: rtl/banked_seq_pkg.sv
package banked_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_DATA   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;

endpackage

// File: rtl/bws_lane_steer.sv
module bws_lane_steer #(
    parameter int LANE_W = 8,
    parameter int AW     = 20,
    localparam int DW    = 2 * LANE_W
) (
    input  logic [AW-1:0] cyc_addr,
    input  logic          aligned_word,
    input  logic          split_second,
    input  logic [DW-1:0] wdata,
    output logic          lo_sel,
    output logic          hi_sel,
    output logic [DW-1:0] wlanes
);

    logic odd_addr;

    always_comb begin
        odd_addr = cyc_addr[0];
        lo_sel   = !odd_addr;
        hi_sel   = aligned_word || odd_addr;

        // Upper lane: word high byte when aligned; otherwise the low byte
        // of the request goes up whenever the cycle targets an odd address.
        if (aligned_word)
            wlanes[DW-1:LANE_W] = wdata[DW-1:LANE_W];
        else if (odd_addr)
            wlanes[DW-1:LANE_W] = wdata[LANE_W-1:0];
        else
            wlanes[DW-1:LANE_W] = '0;

        // Lower lane: the second half of a split word carries the high byte.
        if (aligned_word)
            wlanes[LANE_W-1:0] = wdata[LANE_W-1:0];
        else if (!odd_addr && split_second)
            wlanes[LANE_W-1:0] = wdata[DW-1:LANE_W];
        else if (!odd_addr)
            wlanes[LANE_W-1:0] = wdata[LANE_W-1:0];
        else
            wlanes[LANE_W-1:0] = '0;
    end

endmodule

// File: rtl/bws_read_merge.sv
module bws_read_merge #(
    parameter int LANE_W = 8,
    localparam int DW    = 2 * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          aligned_word,
    input  logic          split,
    input  logic          split_second,
    input  logic          odd_addr,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] rdata
);

    logic [LANE_W-1:0] low_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            low_hold <= '0;
        end else if (capture) begin
            if (aligned_word) begin
                rdata <= ad_in;
            end else if (split && !split_second) begin
                low_hold <= ad_in[DW-1:LANE_W];
            end else if (split) begin
                rdata <= {ad_in[LANE_W-1:0], low_hold};
            end else if (odd_addr) begin
                rdata <= {{LANE_W{1'b0}}, ad_in[DW-1:LANE_W]};
            end else begin
                rdata <= {{LANE_W{1'b0}}, ad_in[LANE_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/bws_ctrl.sv
module bws_ctrl
    import banked_seq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic          ready,
    output logic          accept,
    output logic          busy,
    output logic          done,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          drive_data,
    output logic          bus_active,
    output logic          capture,
    output logic [AW-1:0] cyc_addr,
    output logic          aligned_word,
    output logic          split,
    output logic          split_second
);

    seq_state_t    state_q, state_d;
    logic          write_q, word_q, split_q, second_q;
    logic [AW-1:0] addr_q;
    logic          last_cycle;

    assign last_cycle = !(split_q && !second_q);
    assign accept     = (state_q == ST_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request context and split-half tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q  <= 1'b0;
            word_q   <= 1'b0;
            split_q  <= 1'b0;
            second_q <= 1'b0;
            addr_q   <= '0;
        end else if (accept) begin
            write_q  <= req_write;
            word_q   <= req_word;
            split_q  <= req_word && req_addr[0];
            second_q <= 1'b0;
            addr_q   <= req_addr;
        end else if (state_q == ST_DATA && ready && !last_cycle) begin
            second_q <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_DATA;
            ST_DATA:   if (ready) state_d = last_cycle ? ST_FINISH : ST_ADDR;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ale          = 1'b0;
        rd_n         = 1'b1;
        wr_n         = 1'b1;
        drive_data   = 1'b0;
        bus_active   = 1'b0;
        capture      = 1'b0;
        done         = 1'b0;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_ADDR: begin
                ale        = 1'b1;
                bus_active = 1'b1;
            end
            ST_DATA: begin
                bus_active = 1'b1;
                rd_n       = write_q;
                wr_n       = !write_q;
                drive_data = write_q;
                capture    = ready && !write_q;
            end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
        cyc_addr     = second_q ? addr_q + AW'(1) : addr_q;
        aligned_word = word_q && !split_q;
        split        = split_q;
        split_second = second_q;
    end

endmodule

// File: rtl/banked_access_seq.sv
module banked_access_seq #(
    parameter int AW     = 20,
    parameter int LANE_W = 8,
    localparam int DW    = 2 * LANE_W,
    localparam int HI_W  = AW - DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_word,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rdata,
    output logic            ale,
    output logic [DW-1:0]   ad_out,
    output logic            ad_oe,
    input  logic [DW-1:0]   ad_in,
    output logic [HI_W-1:0] a_hi,
    output logic            hi_en_n,
    output logic            rd_n,
    output logic            wr_n,
    input  logic            ready
);

    logic          accept, drive_data, bus_active, capture;
    logic          aligned_word, split, split_second;
    logic          lo_sel, hi_sel;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] wdata_q, wlanes;

    bws_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_word     (req_word),
        .req_addr     (req_addr),
        .ready        (ready),
        .accept       (accept),
        .busy         (busy),
        .done         (done),
        .ale          (ale),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .drive_data   (drive_data),
        .bus_active   (bus_active),
        .capture      (capture),
        .cyc_addr     (cyc_addr),
        .aligned_word (aligned_word),
        .split        (split),
        .split_second (split_second)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wdata_q <= '0;
        else if (accept) wdata_q <= req_wdata;
    end

    bws_lane_steer #(.LANE_W(LANE_W), .AW(AW)) u_steer (
        .cyc_addr     (cyc_addr),
        .aligned_word (aligned_word),
        .split_second (split_second),
        .wdata        (wdata_q),
        .lo_sel       (lo_sel),
        .hi_sel       (hi_sel),
        .wlanes       (wlanes)
    );

    bws_read_merge #(.LANE_W(LANE_W)) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .aligned_word (aligned_word),
        .split        (split),
        .split_second (split_second),
        .odd_addr     (!lo_sel),
        .ad_in        (ad_in),
        .rdata        (rdata)
    );

    always_comb begin
        ad_oe   = ale || drive_data;
        ad_out  = ale ? cyc_addr[DW-1:0] : (drive_data ? wlanes : '0);
        a_hi    = bus_active ? cyc_addr[AW-1:DW] : '0;
        hi_en_n = !(bus_active && hi_sel);
    end

endmodule

// File: rtl/bws_checker.sv
module bws_checker (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic hi_en_n,
    input logic ad_oe,
    input logic ready,
    input logic done,
    input logic busy
);

    logic seen_edge = 1'b0;
    always @(posedge clk) seen_edge <= 1'b1;

    // R1
    always @(negedge clk) begin
        if (seen_edge && !rst_n) begin
            a_r1_reset_quiet: assert (!ale && rd_n && wr_n && hi_en_n && !ad_oe && !busy && !done);
        end
    end

    a_r2_addr_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!rd_n || !wr_n));

    a_r2_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !ready) |=> !rd_n);

    a_r2_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !ready) |=> !wr_n);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r2_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ready));

    a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind banked_access_seq bws_checker u_bws_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .hi_en_n (hi_en_n),
    .ad_oe   (ad_oe),
    .ready   (ready),
    .done    (done),
    .busy    (busy)
);

// File: tb/tb_banked_access_seq.sv
`timescale 1ns/1ps
module tb_banked_access_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, ale, ad_oe, hi_en_n, rd_n, wr_n, ready;
    logic [15:0] rdata, ad_out, ad_in;
    logic [3:0]  a_hi;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    banked_access_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .ale(ale), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .hi_en_n(hi_en_n),
        .rd_n(rd_n), .wr_n(wr_n), .ready(ready)
    );

    // Bench memory: two 256-byte banks indexed by address bits 8:1
    logic [7:0]  lo_mem [256];
    logic [7:0]  hi_mem [256];
    logic [19:0] lat_addr = '0;
    logic        lat_hien = 1'b1;
    int          wait_cfg = 0, wait_left = 0, ale_cnt = 0, done_cnt = 0;
    logic [7:0]  idx;

    assign idx   = lat_addr[8:1];
    assign ready = (wait_left == 0);
    assign ad_in = !rd_n ? {(!hi_en_n ? hi_mem[idx] : 8'hEE),
                            (!lat_addr[0] ? lo_mem[idx] : 8'hEE)} : 16'hDEAD;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                lo_mem[i] <= 8'h00;
                hi_mem[i] <= 8'h00;
            end
        end else begin
            if (ale) begin
                lat_addr  <= {a_hi, ad_out};
                lat_hien  <= hi_en_n;
                wait_left <= wait_cfg;
                ale_cnt   <= ale_cnt + 1;
            end else if ((!rd_n || !wr_n) && wait_left != 0) begin
                wait_left <= wait_left - 1;
            end
            if (!wr_n && ready) begin
                if (!lat_addr[0]) lo_mem[idx] <= ad_out[7:0];
                if (!hi_en_n)     hi_mem[idx] <= ad_out[15:8];
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One transfer; returns read data, bus cycles, latency and done pulses
    task automatic xfer(input logic w, input logic wd, input logic [19:0] a,
                        input logic [15:0] d, input int wt,
                        output logic [15:0] rv, output int ncyc,
                        output int lat, output int ndone);
        int a0, d0;
        a0 = ale_cnt; d0 = done_cnt;
        wait_cfg = wt;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        rv  = 16'hxxxx;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            lat++;
            if (done) begin
                rv = rdata;
                break;
            end
        end
        @(negedge clk);
        ncyc  = ale_cnt - a0;
        ndone = done_cnt - d0;
        wait_cfg = 0;
    endtask

    task automatic t_reset();
        check("R1 reset outputs", {25'd0, ale, rd_n, wr_n, hi_en_n, ad_oe, busy, done},
              {25'd0, 7'b0111000});
    endtask

    task automatic t_aligned();
        logic [15:0] rv; int nc, lt, nd;
        xfer(1, 1, 20'h00010, 16'h1234, 0, rv, nc, lt, nd);
        check("R5 aligned word write cycles", nc, 1);
        check("R8 aligned latency", lt, 2);
        check("R3 aligned both banks", {lat_hien, lat_addr[0]}, 2'b00);
        xfer(0, 1, 20'h00010, 16'h0, 0, rv, nc, lt, nd);
        check("R5 aligned word read", rv, 16'h1234);
        xfer(0, 0, 20'h00010, 16'h0, 0, rv, nc, lt, nd);
        check("R7 byte read even (little-endian low)", rv, 16'h0034);
        xfer(0, 0, 20'h00011, 16'h0, 0, rv, nc, lt, nd);
        check("R7 byte read odd (little-endian high)", rv, 16'h0012);
    endtask

    task automatic t_bytes();
        logic [15:0] rv; int nc, lt, nd;
        xfer(1, 0, 20'h00020, 16'h77AB, 0, rv, nc, lt, nd);
        check("R3 even byte selects even bank only", {lat_hien, lat_addr[0]}, 2'b10);
        check("R4 even byte cycles", nc, 1);
        xfer(1, 0, 20'h00023, 16'h66CD, 0, rv, nc, lt, nd);
        check("R3 odd byte selects odd bank only", {lat_hien, lat_addr[0]}, 2'b01);
        xfer(0, 1, 20'h00020, 16'h0, 0, rv, nc, lt, nd);
        check("R4 even byte on lane 7:0, neighbour untouched", rv, 16'h00AB);
        xfer(0, 1, 20'h00022, 16'h0, 0, rv, nc, lt, nd);
        check("R4 odd byte on lane 15:8, neighbour untouched", rv, 16'hCD00);
    endtask

    task automatic t_odd_word();
        logic [15:0] rv; int nc, lt, nd;
        xfer(1, 1, 20'h00031, 16'hBEEF, 0, rv, nc, lt, nd);
        check("R6 odd word write cycles", nc, 2);
        check("R8 split latency", lt, 4);
        check("R6 second cycle address", lat_addr, 20'h00032);
        xfer(0, 0, 20'h00031, 16'h0, 0, rv, nc, lt, nd);
        check("R6 low byte at odd address", rv, 16'h00EF);
        xfer(0, 0, 20'h00032, 16'h0, 0, rv, nc, lt, nd);
        check("R6 high byte at next address", rv, 16'h00BE);
        xfer(0, 1, 20'h00030, 16'h0, 0, rv, nc, lt, nd);
        check("R6 even byte below untouched", rv, 16'hEF00);
        xfer(0, 1, 20'h00031, 16'h0, 0, rv, nc, lt, nd);
        check("R6 odd word read merged", rv, 16'hBEEF);
        check("R6 odd word read cycles", nc, 2);
        check("R8 odd word single done", nd, 1);
    endtask

    task automatic t_ready();
        logic [15:0] rv; int nc, lt, nd;
        xfer(1, 1, 20'h00040, 16'hA5C3, 3, rv, nc, lt, nd);
        check("R2 aligned write held by ready", lt, 5);
        xfer(0, 1, 20'h00041, 16'h0, 3, rv, nc, lt, nd);
        check("R2 split read held by ready", lt, 10);
        check("R8 stalled split single done", nd, 1);
        check("R6 stalled split read value", rv, 16'h00A5);
    endtask

    task automatic t_busy();
        logic [15:0] rv; int nc, lt, nd; int a0, d0;
        a0 = ale_cnt; d0 = done_cnt;
        wait_cfg = 4;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_word = 1; req_addr = 20'h00050; req_wdata = 16'h5555;
        @(negedge clk);
        req_addr = 20'h00060; req_wdata = 16'h9999;
        check("R9 busy after accept", busy, 1);
        repeat (3) @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 50; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
        wait_cfg = 0;
        @(negedge clk);
        check("R9 held request starts no cycle", ale_cnt - a0, 1);
        check("R9 one done only", done_cnt - d0, 1);
        xfer(0, 1, 20'h00060, 16'h0, 0, rv, nc, lt, nd);
        check("R9 ignored request wrote nothing", rv, 16'h0000);
        xfer(0, 1, 20'h00050, 16'h0, 0, rv, nc, lt, nd);
        check("R9 accepted request data", rv, 16'h5555);
    endtask

    task automatic t_wrap();
        logic [15:0] rv; int nc, lt, nd;
        xfer(1, 1, 20'hFFFFF, 16'hC3A5, 0, rv, nc, lt, nd);
        check("R10 wrapped second address", lat_addr, 20'h00000);
        xfer(0, 0, 20'hFFFFF, 16'h0, 0, rv, nc, lt, nd);
        check("R10 low byte at top", rv, 16'h00A5);
        xfer(0, 0, 20'h00000, 16'h0, 0, rv, nc, lt, nd);
        check("R10 high byte at zero", rv, 16'h00C3);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_aligned();
        t_bytes();
        t_odd_word();
        t_ready();
        t_busy();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule